// File: doc/BRIEF.md
# Pipeline Operand Bypass Network

This block chooses, for each of the two ALU operands of a five-stage in-order integer pipeline, where the operand value comes from. The instruction now entering execute names two source registers. Each source can take one of three values: the value read from the register file, the result held after the execute stage, or the result held after the memory stage. The choice depends on which older in-flight instruction writes that register.

The logic is purely combinational. It contains the index comparators, a priority choice for each operand and a three-way multiplexer for each operand. The surrounding pipeline supplies the register indices, the write enables and the values. The block returns the two selected operands and a two-bit source code for each one, so that the choice can be observed.

Top module: `byp_operand_net`

## Requirements
- R1: When neither producer qualifies for an operand, its source code is 0 and the operand equals that operand's register-file value. Code 3 never appears.
- R2: A producer qualifies for an operand only when its write enable is 1, its destination is nonzero, and its destination equals the operand's source index. When the execute-side producer qualifies, the source code is 1 and the operand equals the execute-side result.
- R3: When the execute-side producer does not qualify and the memory-side producer does, the source code is 2 and the operand equals the memory-side result.
- R4: When both producers qualify for the same source, the execute-side (younger) result is chosen and the code is 1.
- R5: A producer whose write enable is 0 is never chosen, even if its destination equals the source index.
- R6: A producer with destination register 0 is never chosen. An execute-side producer writing register 0 does not hide a qualifying memory-side producer, so that case gives code 2.
- R7: Operands A and B are resolved independently. In the same cycle one may take code 1 while the other takes code 2.
- R8: The memory-side value is passed through unchanged whatever it holds, for example loaded data, over the full 32-bit width.
- R9: For the sequence x5=10, x6=x5+x5, x7=x6-x5, the second instruction receives 10/10 with codes 1/1. The third receives 20/10 with codes 1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Source register index of operand A |
| src_b_idx | input | 5 | Source register index of operand B |
| rf_a_val | input | 32 | Register-file value for operand A |
| rf_b_val | input | 32 | Register-file value for operand B |
| ex_wen | input | 1 | Execute-side producer will write a register |
| ex_dst | input | 5 | Execute-side producer destination index |
| ex_val | input | 32 | Execute-side producer result |
| wb_wen | input | 1 | Memory-side producer will write a register |
| wb_dst | input | 5 | Memory-side producer destination index |
| wb_val | input | 32 | Memory-side producer result or loaded data |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| sel_a | output | 2 | Source code of operand A (0 register file, 1 execute side, 2 memory side) |
| sel_b | output | 2 | Source code of operand B, same encoding |

## Verification
The block holds no state, so any fault in a comparator, the priority choice or a multiplexer appears at the ports in the same cycle as the inputs that trigger it. A faulty comparator or priority choice shows up as a wrong source code. A multiplexer with miswired data legs keeps the correct code but delivers the wrong operand value. Random stimulus draws register indices from a narrow range, so overlapping matches, matches on register 0 and disabled writers occur often. Directed cases cover the priority conflict, the register-0 case that must not hide an older producer, and the three-instruction sequence.

// File: rtl/byp_pkg.sv
package byp_pkg;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF   = 2'd0,
        SRC_NEAR = 2'd1,
        SRC_FAR  = 2'd2
    } src_e;
endpackage

// File: rtl/byp_hit.sv
module byp_hit #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             wen,
    input  logic [IDX_W-1:0] dst,
    input  logic [IDX_W-1:0] src,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/byp_pick.sv
module byp_pick
    import byp_pkg::*;
(
    input  logic near_hit,
    input  logic far_hit,
    output src_e sel
);
    always_comb begin
        if (near_hit)     sel = SRC_NEAR;
        else if (far_hit) sel = SRC_FAR;
        else              sel = SRC_RF;
    end
endmodule

// File: rtl/byp_mux.sv
module byp_mux
    import byp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  src_e              sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] near_val,
    input  logic [DATA_W-1:0] far_val,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_NEAR: y = near_val;
            SRC_FAR:  y = far_val;
            default:  y = rf_val;
        endcase
    end
endmodule

// File: rtl/byp_operand_net.sv
module byp_operand_net
    import byp_pkg::*;
(
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [DATA_W-1:0] rf_a_val,
    input  logic [DATA_W-1:0] rf_b_val,
    input  logic              ex_wen,
    input  logic [IDX_W-1:0]  ex_dst,
    input  logic [DATA_W-1:0] ex_val,
    input  logic              wb_wen,
    input  logic [IDX_W-1:0]  wb_dst,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [SEL_W-1:0]  sel_a,
    output logic [SEL_W-1:0]  sel_b
);
    localparam int unsigned N_OPND = 2;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] val;
    } opnd_t;

    logic [IDX_W-1:0]  src_idx [N_OPND];
    logic [DATA_W-1:0] rf_val  [N_OPND];
    opnd_t             res_d   [N_OPND];

    always_comb begin
        src_idx[0] = src_a_idx;
        src_idx[1] = src_b_idx;
        rf_val[0]  = rf_a_val;
        rf_val[1]  = rf_b_val;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic              near_hit;
        logic              far_hit;
        src_e              sel;
        logic [DATA_W-1:0] val;

        byp_hit #(.IDX_W(IDX_W)) u_near_hit (
            .wen (ex_wen),
            .dst (ex_dst),
            .src (src_idx[g]),
            .hit (near_hit)
        );

        byp_hit #(.IDX_W(IDX_W)) u_far_hit (
            .wen (wb_wen),
            .dst (wb_dst),
            .src (src_idx[g]),
            .hit (far_hit)
        );

        byp_pick u_pick (
            .near_hit (near_hit),
            .far_hit  (far_hit),
            .sel      (sel)
        );

        byp_mux #(.DATA_W(DATA_W)) u_mux (
            .sel      (sel),
            .rf_val   (rf_val[g]),
            .near_val (ex_val),
            .far_val  (wb_val),
            .y        (val)
        );

        always_comb begin
            res_d[g].sel = sel;
            res_d[g].val = val;
        end
    end

    always_comb begin
        opnd_a = res_d[0].val;
        sel_a  = res_d[0].sel;
        opnd_b = res_d[1].val;
        sel_b  = res_d[1].sel;
    end
endmodule

// File: rtl/byp_operand_chk.sv
module byp_operand_chk
    import byp_pkg::*;
(
    input logic [IDX_W-1:0]  src_a_idx,
    input logic [IDX_W-1:0]  src_b_idx,
    input logic [DATA_W-1:0] rf_a_val,
    input logic [DATA_W-1:0] rf_b_val,
    input logic              ex_wen,
    input logic [IDX_W-1:0]  ex_dst,
    input logic [DATA_W-1:0] ex_val,
    input logic              wb_wen,
    input logic [IDX_W-1:0]  wb_dst,
    input logic [DATA_W-1:0] wb_val,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [SEL_W-1:0]  sel_a,
    input logic [SEL_W-1:0]  sel_b
);
    logic ex_ok, wb_ok;
    assign ex_ok = ex_wen && (ex_dst != '0);
    assign wb_ok = wb_wen && (wb_dst != '0);

    always_comb begin
        p_no_code3_r1: assert (sel_a != 2'd3 && sel_b != 2'd3);
        if (!(ex_ok && ex_dst == src_a_idx) && !(wb_ok && wb_dst == src_a_idx))
            p_rf_a_r1: assert (sel_a == 2'd0 && opnd_a == rf_a_val);
        if (ex_ok && ex_dst == src_b_idx)
            p_near_b_r4: assert (sel_b == 2'd1 && opnd_b == ex_val);
        if (ex_ok && ex_dst == src_a_idx)
            p_near_a_r2: assert (sel_a == 2'd1 && opnd_a == ex_val);
        if (!(ex_ok && ex_dst == src_a_idx) && wb_ok && wb_dst == src_a_idx)
            p_far_a_r3: assert (sel_a == 2'd2 && opnd_a == wb_val);
        if (!ex_wen)
            p_wen_off_r5: assert (sel_a != 2'd1 && sel_b != 2'd1);
        if (ex_dst == '0 && wb_dst == '0)
            p_zero_dst_r6: assert (sel_a == 2'd0 && sel_b == 2'd0);
    end
endmodule

bind byp_operand_net byp_operand_chk u_chk (
    .src_a_idx (src_a_idx),
    .src_b_idx (src_b_idx),
    .rf_a_val  (rf_a_val),
    .rf_b_val  (rf_b_val),
    .ex_wen    (ex_wen),
    .ex_dst    (ex_dst),
    .ex_val    (ex_val),
    .wb_wen    (wb_wen),
    .wb_dst    (wb_dst),
    .wb_val    (wb_val),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
);

// File: tb/test_byp_operand_net.sv
module test_byp_operand_net;
    logic        clk = 1'b0;
    logic [4:0]  src_a_idx, src_b_idx, ex_dst, wb_dst;
    logic [31:0] rf_a_val, rf_b_val, ex_val, wb_val, opnd_a, opnd_b;
    logic        ex_wen, wb_wen;
    logic [1:0]  sel_a, sel_b;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    byp_operand_net i_byp_operand_net (.*);

    function automatic logic [1:0] exp_sel(input logic [4:0] src);
        if (ex_wen && ex_dst != 5'd0 && ex_dst == src) return 2'd1;
        if (wb_wen && wb_dst != 5'd0 && wb_dst == src) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'd1) ? ex_val : (s == 2'd2) ? wb_val : rf;
    endfunction

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic [31:0] ra, input logic [31:0] rb,
                         input logic ew, input logic [4:0] ed, input logic [31:0] ev,
                         input logic ww, input logic [4:0] wd, input logic [31:0] wv);
        @(posedge clk);
        src_a_idx = sa; src_b_idx = sb; rf_a_val = ra; rf_b_val = rb;
        ex_wen = ew; ex_dst = ed; ex_val = ev;
        wb_wen = ww; wb_dst = wd; wb_val = wv;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] es_a, input logic [31:0] ev_a,
                       input logic [1:0] es_b, input logic [31:0] ev_b);
        checks++;
        if (sel_a !== es_a || opnd_a !== ev_a || sel_b !== es_b || opnd_b !== ev_b) begin
            failures++;
            $display("FAIL %s: actual sel=%0d/%0d opnd=%h/%h expected sel=%0d/%0d opnd=%h/%h",
                     req, sel_a, sel_b, opnd_a, opnd_b, es_a, es_b, ev_a, ev_b);
        end
    endtask

    task automatic chk_model(input string req);
        logic [1:0] sa, sb;
        sa = exp_sel(src_a_idx);
        sb = exp_sel(src_b_idx);
        chk(req, sa, exp_val(sa, rf_a_val), sb, exp_val(sb, rf_b_val));
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        // R1: no producer qualifies
        drive(5'd3, 5'd4, 32'h11, 32'h22, 1'b1, 5'd9, 32'hAA, 1'b1, 5'd10, 32'hBB);
        chk("R1", 2'd0, 32'h11, 2'd0, 32'h22);
        // R2: execute-side match on A only
        drive(5'd3, 5'd4, 32'h11, 32'h22, 1'b1, 5'd3, 32'hAA, 1'b0, 5'd4, 32'hBB);
        chk("R2", 2'd1, 32'hAA, 2'd0, 32'h22);
        // R3: memory-side match on B
        drive(5'd3, 5'd4, 32'h11, 32'h22, 1'b1, 5'd8, 32'hAA, 1'b1, 5'd4, 32'hBB);
        chk("R3", 2'd0, 32'h11, 2'd2, 32'hBB);
        // R4: both producers match both sources
        drive(5'd12, 5'd12, 32'h1, 32'h2, 1'b1, 5'd12, 32'hCAFE, 1'b1, 5'd12, 32'hBEEF);
        chk("R4", 2'd1, 32'hCAFE, 2'd1, 32'hCAFE);
        // R5: writes disabled on both producers
        drive(5'd12, 5'd13, 32'h1, 32'h2, 1'b0, 5'd12, 32'hCAFE, 1'b0, 5'd13, 32'hBEEF);
        chk("R5", 2'd0, 32'h1, 2'd0, 32'h2);
        // R5: execute side disabled, memory side still forwards
        drive(5'd12, 5'd13, 32'h1, 32'h2, 1'b0, 5'd12, 32'hCAFE, 1'b1, 5'd12, 32'hBEEF);
        chk("R5", 2'd2, 32'hBEEF, 2'd0, 32'h2);
        // R6: reading x0 with producers writing x0
        drive(5'd0, 5'd0, 32'h0, 32'h0, 1'b1, 5'd0, 32'h55, 1'b1, 5'd0, 32'h66);
        chk("R6", 2'd0, 32'h0, 2'd0, 32'h0);
        // R6: execute-side x0 writer must not hide memory-side producer
        drive(5'd0, 5'd7, 32'h0, 32'h3, 1'b1, 5'd0, 32'h55, 1'b1, 5'd7, 32'h77);
        chk("R6", 2'd0, 32'h0, 2'd2, 32'h77);
        // R7: independent resolution
        drive(5'd6, 5'd5, 32'h1, 32'h2, 1'b1, 5'd6, 32'h20, 1'b1, 5'd5, 32'h10);
        chk("R7", 2'd1, 32'h20, 2'd2, 32'h10);
        // R8: loaded data of full width passed through memory side
        drive(5'd9, 5'd31, 32'h0, 32'h0, 1'b1, 5'd1, 32'h0, 1'b1, 5'd9, 32'hFFFF_FFFF);
        chk("R8", 2'd2, 32'hFFFF_FFFF, 2'd0, 32'h0);
        drive(5'd31, 5'd31, 32'h0, 32'h0, 1'b0, 5'd31, 32'h0, 1'b1, 5'd31, 32'h8000_0001);
        chk("R8", 2'd2, 32'h8000_0001, 2'd2, 32'h8000_0001);
        // R9: x5=10; x6=x5+x5; x7=x6-x5
        drive(5'd5, 5'd5, 32'h0, 32'h0, 1'b1, 5'd5, 32'd10, 1'b0, 5'd0, 32'h0);
        chk("R9", 2'd1, 32'd10, 2'd1, 32'd10);
        drive(5'd6, 5'd5, 32'h0, 32'h0, 1'b1, 5'd6, 32'd20, 1'b1, 5'd5, 32'd10);
        chk("R9", 2'd1, 32'd20, 2'd2, 32'd10);
        // R1 R2 R3 R4 R5 R6 R7: random mix over a narrow index range
        for (int i = 0; i < 600; i++) begin
            drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  $urandom, $urandom,
                  1'($urandom), 5'($urandom_range(0, 3)), $urandom,
                  1'($urandom), 5'($urandom_range(0, 3)), $urandom);
            chk_model("R1-random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule